// File: doc/BRIEF.md
# Operate Group-1 Microinstruction Unit

This block carries out the register-only operate instructions of the first group for a 12-bit accumulator machine with a 1-bit link register. The unit receives an instruction word together with the current accumulator and link. It returns the updated accumulator and link, and a flag that tells whether the word belongs to group 1. A single word can enable several micro-operations at once. The unit applies them in one fixed order, and each intermediate value stays 12 bits wide.

A processor's execute stage presents a word with `in_valid`. One clock later the result appears with `out_valid`. The registered outputs keep their value until the next valid word arrives, so the surrounding datapath can write them back whenever it likes. A word outside group 1 passes the accumulator and link through unchanged and clears the recognised flag. The processor can therefore route every operate word through the unit and let the flag decide who owns the result.

Top module: `opr1_unit`

## Requirements
- R1: A word presented with `in_valid` high produces its result with `out_valid` high on the next cycle. A cycle without `in_valid` gives `out_valid` low on the following cycle, and `acc_out`, `link_out` and `recognised` keep their previous values.
- R2: `recognised` is 1 exactly when instruction bits 11..9 are 111 and bit 8 is 0 (group 1).
- R3: For a word that is not group 1, `acc_out` equals `acc_in` and `link_out` equals `link_in`.
- R4: Bit 7 clears the accumulator and bit 6 clears the link. Both clears act before any other operation.
- R5: Bit 5 inverts all 12 accumulator bits after the clear, so clear together with invert gives 7777 octal. Bit 4 inverts the link after its clear.
- R6: Bit 0 adds one to the accumulator after both inversions, modulo 4096. When the sum wraps to zero, the link is inverted, not set.
- R7: Bit 3 alone among the rotate bits rotates the 13-bit pair {link, accumulator} right by one place after the increment. With bit 1 also set, it rotates by two places.
- R8: Bit 2 alone among the rotate bits rotates the pair left by one place after the increment. With bit 1 also set, it rotates by two places.
- R9: Bit 1 with neither rotate bit set exchanges the upper and lower 6-bit halves of the accumulator and leaves the link unchanged.
- R10: When bits 3 and 2 are both set, the rotate step leaves the pair as the increment step produced it, whatever bit 1 holds.
- R11: While `rst_n` is low at a clock edge, the next state has `out_valid`, `acc_out`, `link_out` and `recognised` all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Word and register values are presented this cycle |
| instr | input | 12 | Instruction word |
| acc_in | input | 12 | Current accumulator |
| link_in | input | 1 | Current link |
| out_valid | output | 1 | Result registered from the previous cycle's word |
| acc_out | output | 12 | New accumulator |
| link_out | output | 1 | New link |
| recognised | output | 1 | Last word was a group-1 operate word |

## Verification
The bench builds the unit with its default 12-bit word, which makes the swap halves 6 bits wide and the rotate pair 13 bits wide. At this width the 8-bit control field has only 256 combinations. The bench sweeps all of them, each under two accumulator and link pairs, so every mixed ordering case and the both-rotate-bits case occur. Directed words cover the wrap of increment into the link, the two-place rotates that pass a bit through the link, the half swap, and words from other groups passing through unchanged.

// File: rtl/opr1_pkg.sv
// Package: shared decode type and control bit positions of the group-1 unit.
// Assumes a word of at least 12 bits; the control field sits in bits 7..0.
package opr1_pkg;

    localparam int unsigned WORD_BITS = 12;
    localparam int unsigned POS_CLR_A = 7;
    localparam int unsigned POS_CLR_L = 6;
    localparam int unsigned POS_INV_A = 5;
    localparam int unsigned POS_INV_L = 4;
    localparam int unsigned POS_ROT_R = 3;
    localparam int unsigned POS_ROT_L = 2;
    localparam int unsigned POS_TWICE = 1;
    localparam int unsigned POS_INC   = 0;
    localparam int unsigned GROUP_BIT = 8;

    typedef struct packed {
        logic grp1;
        logic clr_a;
        logic clr_l;
        logic inv_a;
        logic inv_l;
        logic rot_r;
        logic rot_l;
        logic twice;
        logic inc;
    } opr1_ctl_t;

endpackage

// File: rtl/opr1_decode.sv
// Module: opr1_decode
// Splits an instruction word into group-1 recognition and micro-op enables.
// Assumes the opcode field is the top three bits and the group bit is bit 8.
module opr1_decode
    import opr1_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_BITS
) (
    input  logic [WORD_W-1:0] word,
    output opr1_ctl_t         ctl
);

    localparam int unsigned OPC_LSB = WORD_W - 3;
    localparam logic [2:0]  OPC_OPR = 3'b111;

    // Purpose: recognise the group and pull out each control bit.
    always_comb begin
        ctl.grp1  = (word[WORD_W-1:OPC_LSB] == OPC_OPR) && !word[GROUP_BIT];
        ctl.clr_a = word[POS_CLR_A];
        ctl.clr_l = word[POS_CLR_L];
        ctl.inv_a = word[POS_INV_A];
        ctl.inv_l = word[POS_INV_L];
        ctl.rot_r = word[POS_ROT_R];
        ctl.rot_l = word[POS_ROT_L];
        ctl.twice = word[POS_TWICE];
        ctl.inc   = word[POS_INC];
    end

endmodule

// File: rtl/opr1_seq_stage.sv
// Module: opr1_seq_stage
// Applies, in order: clear acc, clear link, invert acc, invert link, increment.
// Assumes the caller gates the result with group-1 recognition.
module opr1_seq_stage #(
    parameter int unsigned WORD_W = 12
) (
    input  logic              clr_a,
    input  logic              clr_l,
    input  logic              inv_a,
    input  logic              inv_l,
    input  logic              inc,
    input  logic [WORD_W-1:0] acc_i,
    input  logic              link_i,
    output logic [WORD_W-1:0] acc_o,
    output logic              link_o
);

    logic [WORD_W-1:0] acc_clr;
    logic [WORD_W-1:0] acc_inv;
    logic [WORD_W:0]   acc_sum;
    logic              link_clr;
    logic              link_inv;

    // Purpose: clear step for both registers.
    always_comb begin
        acc_clr  = clr_a ? '0 : acc_i;
        link_clr = clr_l ? 1'b0 : link_i;
    end

    // Purpose: inversion step, each register kept to its own width.
    always_comb begin
        acc_inv  = inv_a ? ~acc_clr : acc_clr;
        link_inv = inv_l ? ~link_clr : link_clr;
    end

    // Purpose: increment modulo 2^WORD_W; the carry out inverts the link.
    always_comb begin
        acc_sum = {1'b0, acc_inv} + {{WORD_W{1'b0}}, inc};
        acc_o   = acc_sum[WORD_W-1:0];
        link_o  = link_inv ^ acc_sum[WORD_W];
    end

endmodule

// File: rtl/opr1_shift_stage.sv
// Module: opr1_shift_stage
// Rotates the link:acc pair by one or two places, or swaps acc halves.
// Assumes an even word width; both rotate bits set means no rotation.
module opr1_shift_stage #(
    parameter int unsigned WORD_W = 12
) (
    input  logic              rot_r,
    input  logic              rot_l,
    input  logic              twice,
    input  logic [WORD_W-1:0] acc_i,
    input  logic              link_i,
    output logic [WORD_W-1:0] acc_o,
    output logic              link_o
);

    localparam int unsigned PAIR_W = WORD_W + 1;
    localparam int unsigned HALF_W = WORD_W / 2;

    typedef enum logic [2:0] {
        SH_NONE, SH_R1, SH_R2, SH_L1, SH_L2, SH_SWAP
    } shift_sel_t;

    logic [PAIR_W-1:0] pair;
    logic [PAIR_W-1:0] pair_r1;
    logic [PAIR_W-1:0] pair_r2;
    logic [PAIR_W-1:0] pair_l1;
    logic [PAIR_W-1:0] pair_l2;
    logic [WORD_W-1:0] acc_swp;
    logic [PAIR_W-1:0] pair_out;
    shift_sel_t        sel;

    assign pair = {link_i, acc_i};

    // Rotated copies of the pair, one wire per bit and per distance.
    for (genvar i = 0; i < PAIR_W; i++) begin : g_rot
        assign pair_r1[i] = pair[(i + 1) % PAIR_W];
        assign pair_r2[i] = pair[(i + 2) % PAIR_W];
        assign pair_l1[i] = pair[(i + PAIR_W - 1) % PAIR_W];
        assign pair_l2[i] = pair[(i + PAIR_W - 2) % PAIR_W];
    end

    // Half-word exchange of the accumulator.
    for (genvar j = 0; j < WORD_W; j++) begin : g_swap
        assign acc_swp[j] = acc_i[(j + HALF_W) % WORD_W];
    end

    // Purpose: pick the shift variant from the three control bits.
    always_comb begin
        unique casez ({rot_r, rot_l, twice})
            3'b11?:  sel = SH_NONE;
            3'b100:  sel = SH_R1;
            3'b101:  sel = SH_R2;
            3'b010:  sel = SH_L1;
            3'b011:  sel = SH_L2;
            3'b001:  sel = SH_SWAP;
            default: sel = SH_NONE;
        endcase
    end

    // Purpose: drive the pair from the chosen variant.
    always_comb begin
        case (sel)
            SH_R1:   pair_out = pair_r1;
            SH_R2:   pair_out = pair_r2;
            SH_L1:   pair_out = pair_l1;
            SH_L2:   pair_out = pair_l2;
            SH_SWAP: pair_out = {link_i, acc_swp};
            default: pair_out = pair;
        endcase
        link_o = pair_out[WORD_W];
        acc_o  = pair_out[WORD_W-1:0];
    end

endmodule

// File: rtl/opr1_unit.sv
// Module: opr1_unit (top)
// Executes one group-1 operate word per valid cycle with a one-cycle
// registered result. Words of other groups pass the registers through.
// Assumes the caller holds the inputs only for the cycle in_valid is high.
module opr1_unit
    import opr1_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] acc_in,
    input  logic              link_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] acc_out,
    output logic              link_out,
    output logic              recognised
);

    localparam int unsigned HALF_W = WORD_W / 2;

    opr1_ctl_t         ctl;
    logic [WORD_W-1:0] seq_acc;
    logic              seq_link;
    logic [WORD_W-1:0] sh_acc;
    logic              sh_link;
    logic [WORD_W-1:0] nxt_acc;
    logic              nxt_link;

    opr1_decode #(.WORD_W(WORD_W)) u_dec (
        .word (instr),
        .ctl  (ctl)
    );

    opr1_seq_stage #(.WORD_W(WORD_W)) u_seq (
        .clr_a  (ctl.clr_a),
        .clr_l  (ctl.clr_l),
        .inv_a  (ctl.inv_a),
        .inv_l  (ctl.inv_l),
        .inc    (ctl.inc),
        .acc_i  (acc_in),
        .link_i (link_in),
        .acc_o  (seq_acc),
        .link_o (seq_link)
    );

    opr1_shift_stage #(.WORD_W(WORD_W)) u_sh (
        .rot_r  (ctl.rot_r),
        .rot_l  (ctl.rot_l),
        .twice  (ctl.twice),
        .acc_i  (seq_acc),
        .link_i (seq_link),
        .acc_o  (sh_acc),
        .link_o (sh_link)
    );

    // Purpose: choose the computed result or the pass-through values.
    always_comb begin
        nxt_acc  = ctl.grp1 ? sh_acc  : acc_in;
        nxt_link = ctl.grp1 ? sh_link : link_in;
    end

    // Purpose: output registers, loaded only for a valid word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            acc_out    <= '0;
            link_out   <= 1'b0;
            recognised <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                acc_out    <= nxt_acc;
                link_out   <= nxt_link;
                recognised <= ctl.grp1;
            end
        end
    end

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(acc_out) && $stable(link_out));

    p_recog_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> recognised == ($past(instr[WORD_W-1:WORD_W-3]) == 3'b111
                                    && !$past(instr[GROUP_BIT])));

    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !ctl.grp1 |=> acc_out == $past(acc_in) && link_out == $past(link_in));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ctl.grp1 && ctl.clr_a && !ctl.inv_a && !ctl.inc
        && !ctl.rot_r && !ctl.rot_l |=> acc_out == '0);

    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ctl.grp1 && ctl.inc && !ctl.clr_a && !ctl.clr_l && !ctl.inv_a
        && !ctl.inv_l && !ctl.rot_r && !ctl.rot_l && !ctl.twice && (&acc_in)
        |=> acc_out == '0 && link_out != $past(link_in));

    p_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ctl.grp1 && ctl.twice && !ctl.rot_r && !ctl.rot_l && !ctl.clr_a
        && !ctl.clr_l && !ctl.inv_a && !ctl.inv_l && !ctl.inc
        |=> acc_out == {$past(acc_in[HALF_W-1:0]), $past(acc_in[WORD_W-1:HALF_W])}
            && link_out == $past(link_in));

endmodule

// File: tb/tb_opr1_unit.sv
module tb_opr1_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] instr = '0;
    logic [11:0] acc_in = '0;
    logic        link_in = 1'b0;
    logic        out_valid;
    logic [11:0] acc_out;
    logic        link_out;
    logic        recognised;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [13:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    opr1_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .acc_in(acc_in), .link_in(link_in), .out_valid(out_valid),
        .acc_out(acc_out), .link_out(link_out), .recognised(recognised)
    );

    // Expected {recognised, link, acc} from the requirement text.
    function automatic logic [13:0] model(logic [11:0] w, logic [11:0] a0, logic l0);
        logic [11:0] a;
        logic        l;
        int          n;
        a = a0;
        l = l0;
        if (w[11:9] != 3'o7 || w[8]) return {1'b0, l0, a0};
        if (w[7]) a = 12'o0000;
        if (w[6]) l = 1'b0;
        if (w[5]) a = a ^ 12'o7777;
        if (w[4]) l = !l;
        if (w[0]) begin
            a = a + 12'o0001;
            if (a == 12'o0000) l = !l;
        end
        n = w[1] ? 2 : 1;
        if (w[3] && !w[2]) begin
            for (int k = 0; k < n; k++) {l, a} = {a[0], l, a[11:1]};
        end else if (w[2] && !w[3]) begin
            for (int k = 0; k < n; k++) {l, a} = {a, l};
        end else if (w[1] && !w[2] && !w[3]) begin
            a = {a[5:0], a[11:6]};
        end
        return {1'b1, l, a};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0o expected %0o", tag, act, exp);
        end
    endtask

    // Driver: present one word and queue its expected result.
    task automatic send(logic [11:0] w, logic [11:0] a, logic l, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        instr    = w;
        acc_in   = a;
        link_in  = l;
        exp_q.push_back(model(w, a, l));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        instr    = 12'o0000;
    endtask

    // Send a word whose result is also given by hand.
    task automatic send_known(logic [11:0] w, logic [11:0] a, logic l,
                              logic [13:0] hand, string tag);
        check({tag, " hand value"}, 32'(model(w, a, l)), 32'(hand));
        send(w, a, l, tag);
    endtask

    // Monitor: pop and compare each registered result.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected out_valid", 32'(1), 32'(0));
            end else begin
                logic [13:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 32'({recognised, link_out, acc_out}), 32'(e));
            end
        end
    end

    initial begin
        logic [13:0] held;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 out_valid", 32'(out_valid), 32'(0));
        check("R11 acc_out", 32'(acc_out), 32'(0));
        check("R11 link_out/recognised", 32'({link_out, recognised}), 32'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // R4/R5: clear then invert accumulator gives all ones
        send_known(12'o7240, 12'o1234, 1'b1, {1'b1, 1'b1, 12'o7777}, "R4 R5 clr+inv acc");
        // R4/R5: clear then invert link gives one
        send_known(12'o7120, 12'o0055, 1'b0, {1'b1, 1'b1, 12'o0055}, "R5 clr+inv link");
        // R6: clear, invert, increment wraps and inverts link
        send_known(12'o7241, 12'o0321, 1'b0, {1'b1, 1'b1, 12'o0000}, "R6 wrap link inverts");
        send_known(12'o7001, 12'o7777, 1'b1, {1'b1, 1'b0, 12'o0000}, "R6 wrap link 1->0");
        send_known(12'o7001, 12'o0777, 1'b1, {1'b1, 1'b1, 12'o1000}, "R6 no wrap");
        // R8: left rotate moves bit 11 into link
        send_known(12'o7004, 12'o4000, 1'b0, {1'b1, 1'b1, 12'o0000}, "R8 rotate left 1");
        send_known(12'o7006, 12'o4000, 1'b1, {1'b1, 1'b0, 12'o0003}, "R8 rotate left 2");
        // R7: right rotate, two places, bit passes through link
        send_known(12'o7010, 12'o0001, 1'b0, {1'b1, 1'b1, 12'o0000}, "R7 rotate right 1");
        send_known(12'o7012, 12'o0001, 1'b0, {1'b1, 1'b0, 12'o4000}, "R7 rotate right 2");
        // R7: rotate after increment
        send_known(12'o7011, 12'o0001, 1'b0, {1'b1, 1'b0, 12'o0001}, "R7 inc then rotate");
        // R9: half swap
        send_known(12'o7002, 12'o0102, 1'b1, {1'b1, 1'b1, 12'o0201}, "R9 swap halves");
        // R10: both rotate bits set
        send_known(12'o7016, 12'o2525, 1'b1, {1'b1, 1'b1, 12'o2525}, "R10 both rotates");
        // R2/R3: words outside group 1
        send_known(12'o7402, 12'o3141, 1'b1, {1'b0, 1'b1, 12'o3141}, "R2 R3 group2 word");
        send_known(12'o1240, 12'o0707, 1'b0, {1'b0, 1'b0, 12'o0707}, "R3 memory word");
        send_known(12'o6041, 12'o7070, 1'b1, {1'b0, 1'b1, 12'o7070}, "R3 iot word");
        idle();
        // R1: idle cycle holds outputs and lowers out_valid
        @(negedge clk);
        check("R1 idle out_valid", 32'(out_valid), 32'(0));
        held = {recognised, link_out, acc_out};
        check("R1 idle hold", 32'(held), 32'({1'b0, 1'b1, 12'o7070}));

        // R2..R10 exhaustive control field sweep, back to back
        for (int i = 0; i < 256; i++) begin
            send({4'b1110, i[7:0]}, 12'((i * 37 + 5) & 12'o7777), i[0], "R2-sweep R7 R8 R9 R10");
            send({4'b1110, i[7:0]}, 12'((i * 1291 + 4000) & 12'o7777), !i[1], "R4-sweep R5 R6");
        end
        idle();
        repeat (3) @(negedge clk);
        check("R1 queue drained", 32'(exp_q.size()), 32'(0));
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule